// File: doc/BRIEF.md
# Back-EMF Sampling Point Scheduler

This block sits beside a six-step commutator in a sensorless brushless motor drive. It decides when the shared ADC samples the phase terminal that is not being driven. In the step whose drive word is 0x12 it waits for the PWM on interval, lets the input settle for a fixed acquisition time, and records the supply voltage. In the step whose drive word is 0x18 it takes over the commutation compare register. It saves the current period, aims the compare at a quarter of the period and then at three quarters. At each of those two points it forces the drive on, waits the acquisition time and starts a conversion. Afterwards it puts the period back unchanged.

Each back-EMF reading is turned into a signed 8-bit error: the reading minus half the supply reading. A speed-lock loop outside this block uses the two errors. A negative first error means the rotor lags. A positive first error and a negative second error mean the drive is locked. The state chain is ST_SUP_WAIT, ST_SUP_ARM, ST_SUP_ACQ, ST_SUP_READ, ST_EMF_WAIT, ST_EMF1_IDLE, ST_EMF1_ACQ, ST_EMF1_READ, ST_EMF2_IDLE, ST_EMF2_ACQ, ST_EMF2_READ, and then back to ST_SUP_WAIT.

The transitions are as follows:
- supply step seen: SUP_WAIT to SUP_ARM
- drive on: SUP_ARM to SUP_ACQ
- delay elapsed: SUP_ACQ to SUP_READ
- conversion done: SUP_READ to EMF_WAIT
- sampling step and PWM tick: EMF_WAIT to EMF1_IDLE
- compare match: EMF1_IDLE to EMF1_ACQ
- delay elapsed: EMF1_ACQ to EMF1_READ
- conversion done: EMF1_READ to EMF2_IDLE
- compare match: EMF2_IDLE to EMF2_ACQ
- delay elapsed: EMF2_ACQ to EMF2_READ
- conversion done: EMF2_READ to SUP_WAIT

Any unused state code falls back to ST_SUP_WAIT.

Top module: `bemf_sample_sched`

## Requirements
- R1: After reset, adc_start, cmp_load, match_clr and force_drive are 0, clr_on_cmp_en is 1, and vsup, delta1 and delta2 are 0.
- R2: A supply sample is armed only while drive_word equals 0x12. It then waits for drive_on = 1. While drive_word is another value, or drive_on is 0, no adc_start is produced.
- R3: adc_start is a one-cycle pulse. It appears ACQ_CYCLES clock edges after the edge that samples the trigger. The trigger is drive_on in the supply step, or cmp_match at a back-EMF point.
- R4: On the adc_done that ends the supply conversion, adc_data is stored in vsup.
- R5: In the wait for the sampling step, the block acts only on the edge where drive_word equals 0x18 and pwm_tick is 1. On that edge it saves period_in as P, loads cmp_value = P>>2 with a cmp_load pulse, and drives clr_on_cmp_en to 0. A tick with any other drive word is ignored.
- R6: On the edge that samples the first cmp_match, cmp_value becomes (P>>2)+(P>>1) modulo 2^PW, with cmp_load and match_clr pulses. force_drive is 1 during each back-EMF acquisition delay.
- R7: At the second back-EMF point, the adc_start pulse comes together with cmp_value = P, a cmp_load pulse, a match_clr pulse and clr_on_cmp_en returning to 1.
- R8: delta1 and delta2 take the value adc_data minus (vsup>>1), modulo 256, on the adc_done of the first and second back-EMF conversions. Bit 7 set means the back-EMF is below half the supply.
- R9: After the second back-EMF result, the chain restarts at the supply step, so the sequence repeats indefinitely.
- R10: cmp_match is ignored outside the two compare-wait states: it causes no cmp_load and no match_clr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| drive_word | input | WW | Current commutation step drive word |
| drive_on | input | 1 | PWM on-interval flag |
| pwm_tick | input | 1 | PWM period synchronising tick |
| period_in | input | PW | Current commutation compare value |
| cmp_match | input | 1 | Compare-match strobe from the commutation timer |
| adc_done | input | 1 | Conversion-complete pulse |
| adc_data | input | DW | Conversion result |
| adc_start | output | 1 | Conversion start pulse |
| force_drive | output | 1 | Forces the high-side drive on for a back-EMF sample |
| cmp_value | output | PW | Compare value written to the commutation timer |
| cmp_load | output | 1 | Load strobe for cmp_value |
| match_clr | output | 1 | Clears the commutator's match flag |
| clr_on_cmp_en | output | 1 | Enables clear-on-compare in the commutator |
| vsup | output | DW | Supply reading |
| delta1 | output | DW | Error at the quarter-period point |
| delta2 | output | DW | Error at the three-quarter-period point |

## Verification
The assertions assume that adc_done comes only after a requested conversion, and at most once per request. They also assume that the commutator honours clr_on_cmp_en, so that the next cmp_match comes only after a new compare value has been loaded. The bench plays both neighbours in that manner. It answers every adc_start with exactly one adc_done pulse, and it pulses cmp_match only after cmp_load, except for the deliberate stray strobes that test R10. The sweep over supply values, readings and periods holds period_in stable throughout the sampling step, as the commutator would.

// File: rtl/bemf_sched_pkg.sv
package bemf_sched_pkg;

    typedef enum logic [3:0] {
        ST_SUP_WAIT  = 4'd0,
        ST_SUP_ARM   = 4'd1,
        ST_SUP_ACQ   = 4'd2,
        ST_SUP_READ  = 4'd3,
        ST_EMF_WAIT  = 4'd4,
        ST_EMF1_IDLE = 4'd5,
        ST_EMF1_ACQ  = 4'd6,
        ST_EMF1_READ = 4'd7,
        ST_EMF2_IDLE = 4'd8,
        ST_EMF2_ACQ  = 4'd9,
        ST_EMF2_READ = 4'd10
    } sched_state_e;

endpackage

// File: rtl/bemf_acq_timer.sv
module bemf_acq_timer #(
    parameter int unsigned CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    // Loaded on start; done flags the last counted cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CW'(CYCLES);
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign done = (cnt == CW'(1));
endmodule

// File: rtl/bemf_delta.sv
module bemf_delta #(
    parameter int unsigned DW = 8
) (
    input  logic [DW-1:0] sample,
    input  logic [DW-1:0] supply,
    output logic [DW-1:0] diff
);
    // Two's-complement error against half the supply, wrapping to DW bits.
    assign diff = sample - (supply >> 1);
endmodule

// File: rtl/bemf_sample_sched.sv
module bemf_sample_sched
    import bemf_sched_pkg::*;
#(
    parameter int unsigned DW         = 8,
    parameter int unsigned PW         = 16,
    parameter int unsigned WW         = 8,
    parameter int unsigned ACQ_CYCLES = 16,
    parameter logic [WW-1:0] SUP_WORD = 8'h12,
    parameter logic [WW-1:0] EMF_WORD = 8'h18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [WW-1:0] drive_word,
    input  logic          drive_on,
    input  logic          pwm_tick,
    input  logic [PW-1:0] period_in,
    input  logic          cmp_match,
    input  logic          adc_done,
    input  logic [DW-1:0] adc_data,
    output logic          adc_start,
    output logic          force_drive,
    output logic [PW-1:0] cmp_value,
    output logic          cmp_load,
    output logic          match_clr,
    output logic          clr_on_cmp_en,
    output logic [DW-1:0] vsup,
    output logic [DW-1:0] delta1,
    output logic [DW-1:0] delta2
);
    sched_state_e  state, state_nx;
    logic          acq_go, acq_done;
    logic [DW-1:0] diff;
    logic [PW-1:0] per_save, per_half;

    bemf_acq_timer #(.CYCLES(ACQ_CYCLES)) u_acq (
        .clk   (clk),
        .rst_n (rst_n),
        .start (acq_go),
        .done  (acq_done)
    );

    bemf_delta #(.DW(DW)) u_delta (
        .sample (adc_data),
        .supply (vsup),
        .diff   (diff)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SUP_WAIT;
        else        state <= state_nx;
    end

    // Next-state logic and acquisition-delay launch
    always_comb begin
        state_nx = state;
        acq_go   = 1'b0;
        unique case (state)
            ST_SUP_WAIT:  if (drive_word == SUP_WORD) state_nx = ST_SUP_ARM;
            ST_SUP_ARM:   if (drive_on) begin
                              acq_go   = 1'b1;
                              state_nx = ST_SUP_ACQ;
                          end
            ST_SUP_ACQ:   if (acq_done) state_nx = ST_SUP_READ;
            ST_SUP_READ:  if (adc_done) state_nx = ST_EMF_WAIT;
            ST_EMF_WAIT:  if (drive_word == EMF_WORD && pwm_tick) state_nx = ST_EMF1_IDLE;
            ST_EMF1_IDLE: if (cmp_match) begin
                              acq_go   = 1'b1;
                              state_nx = ST_EMF1_ACQ;
                          end
            ST_EMF1_ACQ:  if (acq_done) state_nx = ST_EMF1_READ;
            ST_EMF1_READ: if (adc_done) state_nx = ST_EMF2_IDLE;
            ST_EMF2_IDLE: if (cmp_match) begin
                              acq_go   = 1'b1;
                              state_nx = ST_EMF2_ACQ;
                          end
            ST_EMF2_ACQ:  if (acq_done) state_nx = ST_EMF2_READ;
            ST_EMF2_READ: if (adc_done) state_nx = ST_SUP_WAIT;
            default:      state_nx = ST_SUP_WAIT;
        endcase
    end

    assign force_drive = (state == ST_EMF1_ACQ) || (state == ST_EMF2_ACQ);

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            adc_start     <= 1'b0;
            cmp_load      <= 1'b0;
            match_clr     <= 1'b0;
            clr_on_cmp_en <= 1'b1;
            cmp_value     <= '0;
            per_save      <= '0;
            per_half      <= '0;
            vsup          <= '0;
            delta1        <= '0;
            delta2        <= '0;
        end else begin
            adc_start <= 1'b0;
            cmp_load  <= 1'b0;
            match_clr <= 1'b0;
            unique case (state)
                ST_SUP_ACQ:   if (acq_done) adc_start <= 1'b1;
                ST_SUP_READ:  if (adc_done) vsup <= adc_data;
                ST_EMF_WAIT:  if (drive_word == EMF_WORD && pwm_tick) begin
                                  per_save      <= period_in;
                                  per_half      <= period_in >> 1;
                                  cmp_value     <= period_in >> 2;
                                  cmp_load      <= 1'b1;
                                  clr_on_cmp_en <= 1'b0;
                              end
                ST_EMF1_IDLE: if (cmp_match) begin
                                  cmp_value <= cmp_value + per_half;
                                  cmp_load  <= 1'b1;
                                  match_clr <= 1'b1;
                              end
                ST_EMF1_ACQ:  if (acq_done) adc_start <= 1'b1;
                ST_EMF1_READ: if (adc_done) delta1 <= diff;
                ST_EMF2_ACQ:  if (acq_done) begin
                                  adc_start     <= 1'b1;
                                  cmp_value     <= per_save;
                                  cmp_load      <= 1'b1;
                                  match_clr     <= 1'b1;
                                  clr_on_cmp_en <= 1'b1;
                              end
                ST_EMF2_READ: if (adc_done) delta2 <= diff;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/bemf_sched_chk.sv
module bemf_sched_chk #(
    parameter int unsigned DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          adc_start,
    input logic          adc_done,
    input logic          cmp_load,
    input logic          clr_on_cmp_en,
    input logic          force_drive,
    input logic [DW-1:0] vsup,
    input logic [DW-1:0] delta1,
    input logic [DW-1:0] delta2
);
    a_r3_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);

    a_r5_borrow_loads: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clr_on_cmp_en) |-> cmp_load);

    a_r7_restore_loads: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clr_on_cmp_en) |-> cmp_load);

    a_r6_force_when_borrowed: assert property (@(posedge clk) disable iff (!rst_n)
        force_drive |-> !clr_on_cmp_en);

    a_r4_vsup_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(vsup) |-> $past(adc_done));

    a_r8_delta1_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(delta1) |-> $past(adc_done));

    a_r8_delta2_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(delta2) |-> $past(adc_done));
endmodule

bind bemf_sample_sched bemf_sched_chk #(.DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .adc_start     (adc_start),
    .adc_done      (adc_done),
    .cmp_load      (cmp_load),
    .clr_on_cmp_en (clr_on_cmp_en),
    .force_drive   (force_drive),
    .vsup          (vsup),
    .delta1        (delta1),
    .delta2        (delta2)
);

// File: tb/sim_bemf_sample_sched.sv
module sim_bemf_sample_sched;
    localparam int ACQ = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  drive_word = 8'h00;
    logic        drive_on = 1'b0;
    logic        pwm_tick = 1'b0;
    logic [15:0] period_in = 16'h0;
    logic        cmp_match = 1'b0;
    logic        adc_done = 1'b0;
    logic [7:0]  adc_data = 8'h00;
    logic        adc_start, force_drive, cmp_load, match_clr, clr_on_cmp_en;
    logic [15:0] cmp_value;
    logic [7:0]  vsup, delta1, delta2;

    int n_chk = 0;
    int n_err = 0;

    always #5 clk = ~clk;

    bemf_sample_sched #(.ACQ_CYCLES(ACQ)) u0 (
        .clk(clk), .rst_n(rst_n), .drive_word(drive_word), .drive_on(drive_on),
        .pwm_tick(pwm_tick), .period_in(period_in), .cmp_match(cmp_match),
        .adc_done(adc_done), .adc_data(adc_data), .adc_start(adc_start),
        .force_drive(force_drive), .cmp_value(cmp_value), .cmp_load(cmp_load),
        .match_clr(match_clr), .clr_on_cmp_en(clr_on_cmp_en), .vsup(vsup),
        .delta1(delta1), .delta2(delta2)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_start(output int k);
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!adc_start && k < 200);
    endtask

    task automatic adc_reply(input logic [7:0] d);
        adc_done = 1'b1;
        adc_data = d;
        step(1);
        adc_done = 1'b0;
    endtask

    task automatic run_seq(input int it, input logic [7:0] vs, input logic [7:0] a1,
                           input logic [7:0] a2, input logic [15:0] p);
        int k;
        logic [15:0] q, h;
        q = p >> 2;
        h = p >> 1;
        // wrong step word with drive on: nothing starts; stray match ignored
        drive_word = 8'h18; drive_on = 1'b1;
        step(2);
        chk("R2 wrong word", {31'b0, adc_start}, 32'd0);
        cmp_match = 1'b1; step(1); cmp_match = 1'b0;
        chk("R10 stray match load", {31'b0, cmp_load}, 32'd0);
        chk("R10 stray match clr", {31'b0, match_clr}, 32'd0);
        // supply step, drive off
        drive_word = 8'h12; drive_on = 1'b0;
        step(3);
        chk("R2 drive off", {31'b0, adc_start}, 32'd0);
        drive_on = 1'b1;
        wait_start(k);
        chk(it == 0 ? "R3 supply delay" : "R9 restart supply delay", k, ACQ + 1);
        step(1);
        chk("R3 pulse width", {31'b0, adc_start}, 32'd0);
        adc_reply(vs);
        chk("R4 vsup", {24'b0, vsup}, {24'b0, vs});
        // tick in the wrong step is ignored
        drive_on = 1'b0; period_in = p;
        pwm_tick = 1'b1; step(1); pwm_tick = 1'b0; step(1);
        chk("R5 tick wrong word", {31'b0, clr_on_cmp_en}, 32'd1);
        drive_word = 8'h18;
        step(2);
        chk("R5 no tick", {31'b0, clr_on_cmp_en}, 32'd1);
        pwm_tick = 1'b1; step(1); pwm_tick = 1'b0;
        chk("R5 load", {31'b0, cmp_load}, 32'd1);
        chk("R5 quarter", {16'b0, cmp_value}, {16'b0, q});
        chk("R5 borrow", {31'b0, clr_on_cmp_en}, 32'd0);
        step(3);
        // first sample point
        cmp_match = 1'b1; step(1); cmp_match = 1'b0;
        chk("R6 load", {31'b0, cmp_load}, 32'd1);
        chk("R6 clr", {31'b0, match_clr}, 32'd1);
        chk("R6 three quarter", {16'b0, cmp_value}, {16'b0, 16'(q + h)});
        chk("R6 force", {31'b0, force_drive}, 32'd1);
        wait_start(k);
        chk("R3 bemf1 delay", k, ACQ);
        step(1);
        adc_reply(a1);
        chk("R8 delta1", {24'b0, delta1}, {24'b0, 8'(a1 - (vs >> 1))});
        step(2);
        // second sample point
        cmp_match = 1'b1; step(1); cmp_match = 1'b0;
        chk("R6 force 2", {31'b0, force_drive}, 32'd1);
        wait_start(k);
        chk("R3 bemf2 delay", k, ACQ);
        chk("R7 restore", {16'b0, cmp_value}, {16'b0, p});
        chk("R7 load", {31'b0, cmp_load}, 32'd1);
        chk("R7 clr", {31'b0, match_clr}, 32'd1);
        chk("R7 enable", {31'b0, clr_on_cmp_en}, 32'd1);
        step(1);
        adc_reply(a2);
        chk("R8 delta2", {24'b0, delta2}, {24'b0, 8'(a2 - (vs >> 1))});
        step(1);
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #200000;
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual timeout expected completion");
        report();
    end

    initial begin
        step(3);
        chk("R1 adc_start", {31'b0, adc_start}, 32'd0);
        chk("R1 cmp_load", {31'b0, cmp_load}, 32'd0);
        chk("R1 match_clr", {31'b0, match_clr}, 32'd0);
        chk("R1 clr_en", {31'b0, clr_on_cmp_en}, 32'd1);
        chk("R1 force", {31'b0, force_drive}, 32'd0);
        chk("R1 outputs", {8'b0, vsup, delta1, delta2}, 32'd0);
        rst_n = 1'b1;
        step(2);
        for (int i = 0; i < 12; i++) begin
            run_seq(i, 8'(i * 73 + (i == 1 ? 182 : 0)), 8'(i * 29 + 3),
                    8'(255 - i * 41), 16'(32'hFFFF - i * 5471));
        end
        report();
    end
endmodule